// File: doc/BRIEF.md
# Neighbour-Routed Single/Double-Edge PWM Output Stage

This block sits behind a shared free-running timer and turns that timer's compare strobes into a set of PWM pin levels. The timer raises one strobe per compare slot. Slot 0 marks the start of each period. Output n is always driven low by slot n. What drives it high depends on its edge mode. In single-edge mode, the period-start strobe (slot 0) sets it. In double-edge mode, the strobe of the slot just below it (slot n-1) sets it. This lets a double-edge output place both its rising and its falling edge anywhere within the period. Output 1 has slot 0 as its neighbour below, so it rises on slot 0 in both modes.

Each output is a two-state machine with the states LOW and HIGH. The transition SET_EDGE moves LOW to HIGH when the routed set strobe fires. The transition CLEAR_EDGE moves either state to LOW when the clear strobe fires. The transition DISABLE forces LOW while the channel's enable is off. When a set and a clear arrive in the same cycle, the clear wins. The per-channel edge-mode selection is held in a latch that only takes a new value in a cycle where slot 0 strobes. A mode change made during a period therefore cannot reroute edges partway through that period. In the slot-0 cycle itself, the incoming mode is already the one in effect.

All outputs are registered. A strobe present at a rising clock edge shows up on the pins just after that edge.

Top module: `pwm_edge_router`

## Requirements
- R1: After reset, every `pwm_o` bit is 0 and every channel behaves as single-edge until the first slot-0 strobe latches a mode.
- R2: An enabled single-edge output (bit k of `edge_dbl_i` latched as 0) goes high in the cycle after `match_i[0]` is 1, unless it is cleared in that same cycle.
- R3: `pwm_o[k]` (output k+1) goes low in the cycle after `match_i[k+1]` is 1, in both edge modes.
- R4: An enabled double-edge output k+1 goes high in the cycle after `match_i[k]` is 1. For output 1 (k=0) this is `match_i[0]`.
- R5: A single-edge output k+1 with k>0 is unaffected by `match_i[k]`.
- R6: When the set strobe and the clear strobe of one output are 1 in the same cycle, the output is low afterwards.
- R7: While `out_en_i[k]` is 0, `pwm_o[k]` is 0 in the following cycle and ignores all strobes. After re-enabling, it stays low until its next set strobe.
- R8: A change on `edge_dbl_i` takes effect only in a cycle with `match_i[0]` = 1, and it also governs that cycle's routing. In all other cycles, the mode latched at the previous slot-0 strobe is used.
- R9: A double-edge output k+1 with k>0 is not set by `match_i[0]` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| match_i | input | NUM_CH+1 | Compare strobes, bit 0 = period start, bit n = slot n |
| edge_dbl_i | input | NUM_CH | Requested edge mode per output, 1 = double-edge, bit k = output k+1 |
| out_en_i | input | NUM_CH | Per-output enable, bit k = output k+1 |
| pwm_o | output | NUM_CH | Registered PWM levels, bit k = output k+1 |

## Verification
Two things can land on one output in the same cycle: its set and its clear. For a single-edge output these are the period-start strobe and its own slot. For a double-edge output they are the slot below and its own slot. Directed vectors fire both together in each mode, and the result must be a low output (clear wins). A second collision happens in the slot-0 cycle, where a mode change and the slot-0 routing fall together. Vectors that change `edge_dbl_i` alongside a slot-0 strobe are judged by a bench model that applies the new mode in that same cycle. Random vectors with sparse strobes and occasional mode and enable changes are compared cycle by cycle against the same model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        CH_LOW  = 1'b0,
        CH_HIGH = 1'b1
    } ch_state_t;
endpackage

// File: rtl/pwm_mode_latch.sv
module pwm_mode_latch #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [NUM_CH-1:0] mode_req,
    output logic [NUM_CH-1:0] mode_eff
);
    logic [NUM_CH-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (period_start)
            mode_q <= mode_req;
    end

    // new mode governs the slot-0 cycle itself
    always_comb mode_eff = period_start ? mode_req : mode_q;

    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(mode_q));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic pwm_o
);
    ch_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_LOW;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_LOW: begin
                if (en_i && set_i && !clr_i)
                    state_d = CH_HIGH;            // SET_EDGE
            end
            CH_HIGH: begin
                if (!en_i || clr_i)
                    state_d = CH_LOW;             // DISABLE / CLEAR_EDGE
            end
            default: state_d = CH_LOW;
        endcase
    end

    always_comb pwm_o = (state_q == CH_HIGH);

    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o);
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> !pwm_o);
    a_r2_set_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && set_i && !clr_i) |=> pwm_o);
    a_r3_clear_falls: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pwm_o);
endmodule

// File: rtl/pwm_edge_router.sv
module pwm_edge_router #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH:0]   match_i,
    input  logic [NUM_CH-1:0] edge_dbl_i,
    input  logic [NUM_CH-1:0] out_en_i,
    output logic [NUM_CH-1:0] pwm_o
);
    localparam int NUM_SLOTS = NUM_CH + 1;

    logic [NUM_CH-1:0] mode_eff;
    logic [NUM_CH-1:0] set_v;
    logic [NUM_CH-1:0] clr_v;

    pwm_mode_latch #(.NUM_CH(NUM_CH)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (match_i[0]),
        .mode_req     (edge_dbl_i),
        .mode_eff     (mode_eff)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        if (k == 0) begin : g_first
            // neighbour below output 1 is slot 0: same source in both modes
            always_comb set_v[k] = match_i[0];
        end else begin : g_rest
            always_comb set_v[k] = mode_eff[k] ? match_i[k] : match_i[0];
        end
        always_comb clr_v[k] = match_i[k+1];

        pwm_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (out_en_i[k]),
            .set_i (set_v[k]),
            .clr_i (clr_v[k]),
            .pwm_o (pwm_o[k])
        );

        if (k > 0) begin : g_chk
            a_r9_dbl_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_eff[k] && match_i[0] && !match_i[k] && !pwm_o[k]) |=> !pwm_o[k]);
        end
    end

    initial begin
        a_r1_slot_count: assert (NUM_SLOTS == $bits(match_i));
    end
endmodule

// File: tb/tb_pwm_edge_router.sv
module tb_pwm_edge_router;
    localparam int N = 6;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N:0]   match_i = '0;
    logic [N-1:0] edge_dbl_i = '0;
    logic [N-1:0] out_en_i = '0;
    logic [N-1:0] pwm_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [N-1:0] ref_out  = '0;
    logic [N-1:0] ref_mode = '0;

    pwm_edge_router #(.NUM_CH(N)) dut (
        .clk(clk), .rst_n(rst_n), .match_i(match_i),
        .edge_dbl_i(edge_dbl_i), .out_en_i(out_en_i), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [N-1:0] model_next(logic [N-1:0] cur, logic [N-1:0] md_q,
                                                logic [N:0] m, logic [N-1:0] d,
                                                logic [N-1:0] en);
        logic [N-1:0] md = m[0] ? d : md_q;
        logic [N-1:0] nx;
        for (int k = 0; k < N; k++) begin
            logic s = (k == 0) ? m[0] : (md[k] ? m[k] : m[0]);
            logic c = m[k+1];
            nx[k] = !en[k] ? 1'b0 : c ? 1'b0 : s ? 1'b1 : cur[k];
        end
        return nx;
    endfunction

    task automatic check(string tag, logic [N-1:0] exp);
        n_vec++;
        if (pwm_o !== exp) begin
            n_bad++;
            $display("FAIL %s pwm_o=%b expected=%b", tag, pwm_o, exp);
        end
    endtask

    task automatic step(string tag, logic [N:0] m, logic [N-1:0] d, logic [N-1:0] en);
        logic [N-1:0] exp;
        @(negedge clk);
        match_i = m; edge_dbl_i = d; out_en_i = en;
        exp = model_next(ref_out, ref_mode, m, d, en);
        @(posedge clk);
        #1;
        check(tag, exp);
        ref_out = exp;
        if (m[0]) ref_mode = d;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog pwm_o=%b expected=done", pwm_o);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check("R1 reset", '0);
        rst_n = 1'b1;
        step("R1 idle after reset", '0, '0, '1);
        // single-edge operation
        step("R2 slot0 sets all", 7'b000_0001, '0, '1);
        step("R3 slot2 clears out2", 7'b000_0100, '0, '1);
        step("R5 slot2 no set out3 single", 7'b000_0100, '0, '1);
        step("R3 slot1 clears out1", 7'b000_0010, '0, '1);
        step("R6 slot0+slot3 clear wins", 7'b000_1001, '0, '1);
        // mode request mid-period must not reroute
        step("R8 clear all", 7'b111_1110, '1, '1);
        step("R8 slot1 before latch", 7'b000_0010, '1, '1);
        step("R8 slot2 before latch", 7'b000_0100, '1, '1);
        // latch double-edge at slot 0
        step("R9 slot0 only sets out1", 7'b000_0001, '1, '1);
        step("R4 slot1 clears out1 sets out2", 7'b000_0010, '1, '1);
        step("R4 slot2 sets out3", 7'b000_0100, '1, '1);
        step("R6 dbl slot3+slot4 clear wins", 7'b001_1000, '1, '1);
        step("R4 slot4 sets out5", 7'b001_0000, '1, '1);
        // mode back to single governs the slot-0 cycle itself
        step("R8 slot0 switches to single", 7'b000_0001, '0, '1);
        // disable
        step("R7 disable out4", 7'b000_0001, '0, 6'b11_0111);
        step("R7 strobes ignored", 7'b000_1001, '0, 6'b11_0111);
        step("R7 re-enable stays low", 7'b000_0000, '0, '1);
        step("R7 set after re-enable", 7'b000_0001, '0, '1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [N:0]   m;
            logic [N-1:0] d = edge_dbl_i;
            logic [N-1:0] en = out_en_i;
            for (int b = 0; b <= N; b++) m[b] = ($urandom % 5) == 0;
            if ($urandom % 8 == 0) d = N'($urandom);
            if ($urandom % 16 == 0) en = N'($urandom) | N'($urandom);
            step("RND R2 R3 R4 R6 R7 R8", m, d, en);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule